// File: doc/BRIEF.md
# IR carrier transmit modulator

This block is the output stage of an infrared transmitter. An internal down counter makes a square wave carrier with 50% duty. The carrier is gated by a data bit, and the result drives the modulated transmit pin. A single polarity input sets the level of the pin when idle and also inverts the carrier phase. A second pin carries only the envelope, which is the latched data bit with the same polarity applied. An external modulator can use this pin.

The data bit is taken only when a carrier period ends. A change of data therefore never cuts a carrier pulse short. The block runs only when it is enabled and transmit is selected. In any other state both pins stay low, the counter is held at its reload value and the data latch follows the input.

Top module: `ir_carrier_mod`

## Requirements
- R1: When `enable` is 0 or `tx_sel` is 0 (receive), `tx_out` and `env_out` are both 0 one cycle later.
- R2: While running with the latched data bit at 0, `tx_out` equals `polarity` one cycle later.
- R3: While running with the latched data bit at 1, `tx_out` is the carrier XOR `polarity`. The carrier is high for `half_period`+1 cycles and then low for `half_period`+1 cycles, so one period is 2·(`half_period`+1) cycles.
- R4: While running with `env_mode` at 2'b01 or 2'b10, `env_out` is the latched data bit XOR `polarity`.
- R5: While running with `env_mode` at 2'b00 or 2'b11, `env_out` equals `polarity`.
- R6: While running, the data latch loads `data_in` only on the last cycle of a carrier period. A change in the middle of a period first shows on the pins in the cycle after that period ends. While stopped, the latch follows `data_in`.
- R7: Every start from the stopped state begins with a full high half of the carrier.
- R8: While reset is held, and after it is released, both outputs are 0 until the block runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Block enable |
| tx_sel | input | 1 | 1 = transmit, 0 = receive (outputs held low) |
| data_in | input | 1 | Data bit that gates the carrier |
| polarity | input | 1 | Idle level and carrier inversion |
| env_mode | input | 2 | Envelope pin mode: 01/10 follow data, 00/11 hold idle level |
| half_period | input | CNT_W | Carrier half-period minus one, in clock cycles |
| tx_out | output | 1 | Modulated transmit pin |
| env_out | output | 1 | Envelope pin |

## Verification
Both pins are registered, so a change on `enable`, `tx_sel`, `polarity` or `env_mode` appears after the next rising edge. The bench drives and samples on falling edges and reads each result one falling edge after the stimulus. The carrier starts high at the first rising edge after the start. The bench therefore counts sample index i from that edge and expects high when (i / (`half_period`+1)) is even. A data change in the middle of a period is expected on the pins only at sample 2·(`half_period`+1). This is one edge after the period-end load, and the latch-hold test checks that exact sample.

// File: rtl/ir_cm_pkg.sv
package ir_cm_pkg;
  typedef enum logic [1:0] {
    ENV_IDLE_A = 2'b00,
    ENV_FOLLOW = 2'b01,
    ENV_ALT    = 2'b10,
    ENV_IDLE_B = 2'b11
  } env_mode_e;

  function automatic logic env_follows(input logic [1:0] mode);
    return (mode == ENV_FOLLOW) || (mode == ENV_ALT);
  endfunction
endpackage

// File: rtl/ir_cm_carrier.sv
module ir_cm_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_period,
  output logic             phase,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run) begin
      cnt_d = half_period;
      ph_d  = 1'b1;
    end else if (cnt_q == '0) begin
      cnt_d = half_period;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;
  assign wrap  = run && (cnt_q == '0) && !ph_q;
endmodule

// File: rtl/ir_cm_latch.sv
module ir_cm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wrap,
  input  logic data_in,
  output logic data_q
);
  logic load;
  logic q;

  assign load = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= data_in;
  end

  assign data_q = q;
endmodule

// File: rtl/ir_cm_drive.sv
module ir_cm_drive
  import ir_cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       phase,
  input  logic       data_q,
  input  logic       polarity,
  input  logic [1:0] env_mode,
  output logic       tx_out,
  output logic       env_out
);
  logic tx_q, tx_d, env_q, env_d;

  always_comb begin
    tx_d  = 1'b0;
    env_d = 1'b0;
    if (run) begin
      tx_d  = data_q ? (phase ^ polarity) : polarity;
      env_d = env_follows(env_mode) ? (data_q ^ polarity) : polarity;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      env_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      env_q <= env_d;
    end
  end

  assign tx_out  = tx_q;
  assign env_out = env_q;
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tx_sel,
  input  logic             data_in,
  input  logic             polarity,
  input  logic [1:0]       env_mode,
  input  logic [CNT_W-1:0] half_period,
  output logic             tx_out,
  output logic             env_out
);
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_q_n;
  logic              run;
  logic              phase;
  logic              wrap;
  logic              data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[SYNC_N-1];

  assign run = enable && tx_sel;

  ir_cm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst_n(rst_q_n), .run(run), .half_period(half_period),
    .phase(phase), .wrap(wrap)
  );

  ir_cm_latch u_latch (
    .clk(clk), .rst_n(rst_q_n), .run(run), .wrap(wrap),
    .data_in(data_in), .data_q(data_q)
  );

  ir_cm_drive u_drive (
    .clk(clk), .rst_n(rst_q_n), .run(run), .phase(phase), .data_q(data_q),
    .polarity(polarity), .env_mode(env_mode),
    .tx_out(tx_out), .env_out(env_out)
  );
endmodule

// File: rtl/ir_carrier_mod_chk.sv
module ir_carrier_mod_chk
  import ir_cm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       phase,
  input logic       wrap,
  input logic       data_q,
  input logic       polarity,
  input logic [1:0] env_mode,
  input logic       tx_out,
  input logic       env_out
);
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tx_out && !env_out)); // R1
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !data_q) |=> (tx_out == $past(polarity))); // R2
  AST_TX_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    (run && data_q) |=> (tx_out == ($past(phase) ^ $past(polarity)))); // R3
  AST_ENV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && env_follows(env_mode)) |=> (env_out == ($past(data_q) ^ $past(polarity)))); // R4
  AST_ENV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !env_follows(env_mode)) |=> (env_out == $past(polarity))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(data_q)); // R6
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> phase); // R7
endmodule

bind ir_carrier_mod ir_carrier_mod_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .run(run), .phase(phase), .wrap(wrap),
  .data_q(data_q), .polarity(polarity), .env_mode(env_mode),
  .tx_out(tx_out), .env_out(env_out)
);

// File: tb/sim_ir_carrier_mod.sv
module sim_ir_carrier_mod;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic       en;
    logic       tsel;
    logic       data;
    logic       pol;
    logic [1:0] env;
    logic       chk_tx;
    logic       exp_tx;
    logic       exp_env;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0}, // R1 disabled
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0}, // R1 receive
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0}, // R2 R4
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1}, // R2 R4
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1}, // R2 R4
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0}, // R2 R4
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1}, // R4
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1}, // R5
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0}, // R5
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1}  // R5
  };

  logic             clk;
  logic             rst_n;
  logic             enable;
  logic             tx_sel;
  logic             data_in;
  logic             polarity;
  logic [1:0]       env_mode;
  logic [CNT_W-1:0] half_period;
  logic             tx_out;
  logic             env_out;

  int total = 0;
  int bad   = 0;

  ir_carrier_mod #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_sel(tx_sel),
    .data_in(data_in), .polarity(polarity), .env_mode(env_mode),
    .half_period(half_period), .tx_out(tx_out), .env_out(env_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic carrier_run(input int h, input logic pol, input string tag);
    enable = 1'b0; data_in = 1'b1; polarity = pol; env_mode = 2'b01;
    half_period = CNT_W'(h);
    wait_neg(3);
    enable = 1'b1;
    for (int i = 0; i < 4 * (h + 1); i++) begin
      @(negedge clk);
      check(tag, tx_out, (((i / (h + 1)) % 2) == 0) ^ pol);
      check("R4 envelope during carrier", env_out, 1'b1 ^ pol);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; tx_sel = 1'b1; data_in = 1'b0;
    polarity = 1'b1; env_mode = 2'b01; half_period = CNT_W'(2);
    wait_neg(3);
    check("R8 tx in reset", tx_out, 1'b0);
    check("R8 env in reset", env_out, 1'b0);
    rst_n = 1'b1;
    wait_neg(4);
    check("R8 tx after reset", tx_out, 1'b0);
    check("R8 env after reset", env_out, 1'b0);

    for (int r = 0; r < NV; r++) begin
      enable = 1'b0; tx_sel = VEC[r].tsel; data_in = VEC[r].data;
      polarity = VEC[r].pol; env_mode = VEC[r].env;
      wait_neg(2);
      enable = VEC[r].en;
      wait_neg(3);
      if (VEC[r].chk_tx) check($sformatf("table row %0d tx", r), tx_out, VEC[r].exp_tx);
      check($sformatf("table row %0d env", r), env_out, VEC[r].exp_env);
    end

    tx_sel = 1'b1;
    carrier_run(2, 1'b0, "R3 carrier h=2 pol=0");
    carrier_run(3, 1'b1, "R3 R7 carrier h=3 pol=1 restart");

    // R6: data drops in the middle of a period; pins change only after the period ends
    enable = 1'b0; data_in = 1'b1; polarity = 1'b0; env_mode = 2'b01;
    half_period = CNT_W'(2);
    wait_neg(3);
    enable = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R6 latch hold tx", tx_out, (i < 6) ? (((i / 3) % 2) == 0) : 1'b0);
      check("R6 latch hold env", env_out, (i < 6) ? 1'b1 : 1'b0);
      if (i == 1) data_in = 1'b0;
    end

    // R1: dropping enable while running forces both pins low on the next edge
    data_in = 1'b1; polarity = 1'b1;
    wait_neg(8);
    enable = 1'b0;
    @(negedge clk);
    check("R1 stop mid-run tx", tx_out, 1'b0);
    check("R1 stop mid-run env", env_out, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule